// File: doc/BRIEF.md
# Extended Stack Pointer Unit

This block holds the stack pointer of an 8052-style core and works out, for every push and pop, the physical address of the stack access. In normal mode the pointer acts as a plain 8-bit register: it moves only within the 256-byte internal RAM and wraps from FFh to 00h. When the extension bit is set, the pointer grows to 11 bits. The stack then runs from the top of internal RAM (00FFh) into on-chip extension RAM starting at 0100h, and can reach 07FFh. The lowest 256 bytes of extension RAM are never used as stack, so 1792 extension bytes are left for it.

The core reaches the pointer through its register file. The low byte sits at address 81h. The three upper pointer bits sit in the low bits of a second register at B7h. A push increments the pointer first and then writes at the new value. A pop reads at the current value and then decrements. Along with each access address the block gives a flag that tells the memory side which RAM to select. The memories and the instruction decode are outside this block.

Top module: `stk_ptr_unit`

## Requirements
- R1: With extension off, a push from low byte FFh accesses address 000h and leaves the low byte at 00h. The pointer stays within 8 bits.
- R2: With extension on, a push from pointer 0FFh accesses address 100h with the extension flag set. The pointer then holds 100h.
- R3: With extension on, a pop from pointer 100h accesses 100h and leaves the pointer at 0FFh. A following pop accesses 0FFh with the flag clear.
- R4: With extension on, a push from 7FFh accesses 000h and leaves the pointer at 000h. A pop from 000h accesses 000h and leaves the pointer at 7FFh.
- R5: A push drives the incremented pointer as the access address in the same cycle. A pop drives the current pointer. The pointer register takes its new value at the next clock edge.
- R6: stk_in_xram is 0 for access addresses 000h to 0FFh and 1 for 100h to 7FFh. In normal mode the access address always has its bits 10:8 at 0, whatever value the upper field holds.
- R7: Register address 81h reads and writes the pointer low byte. Address B7h holds the upper three pointer bits in bits 2:0. Every other address reads as 00h.
- R8: After reset the low byte is 07h, the upper bits are 0 and extension mode is off.
- R9: Bits 7:3 at address B7h always read 0, and writes to them are ignored.
- R10: A register write to 81h or B7h in the same cycle as a push or pop takes priority. The written field takes the write data and the other field keeps its value. The access address still comes from the old pointer.
- R11: When push and pop come in the same cycle, the push is performed and the pop is ignored.
- R12: In normal mode, pushes and pops never change the upper three pointer bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| push_en | input | 1 | Push request this cycle |
| pop_en | input | 1 | Pop request this cycle |
| cfg_we | input | 1 | Load the extension mode bit |
| cfg_ext | input | 1 | New extension mode value |
| reg_we | input | 1 | Register file write strobe |
| reg_addr | input | 8 | Register file address |
| reg_wdata | input | 8 | Register file write data |
| reg_rdata | output | 8 | Register file read data (combinational) |
| ext_mode | output | 1 | Current extension mode |
| stk_addr | output | 11 | Physical address of this cycle's stack access |
| stk_in_xram | output | 1 | 1 when stk_addr is in extension RAM |

## Verification
Two things can land on the pointer register at the same edge. One is a push or pop. The other is a software write to 81h or B7h. Both can also occur with push and pop requested together. The bench sets the pointer to a known value and then, in a single cycle, asserts a push together with a low-byte write. It checks that the access address of that cycle is the old pointer plus one, and that afterwards the pointer holds the written low byte with its upper bits unchanged. A second scenario asserts push and pop together and expects exactly one increment.

// File: rtl/stkp_pkg.sv
// Package: shared constants and the operation type for the stack pointer unit.
// Assumes: an 8-bit register file data path.
package stkp_pkg;
    localparam int REG_DW = 8;

    typedef enum logic [1:0] {
        OP_NONE = 2'd0,
        OP_PUSH = 2'd1,
        OP_POP  = 2'd2
    } stk_op_e;
endpackage

// File: rtl/stkp_arith.sv
// Module: stkp_arith
// Works out the pointer after a push or pop and the address of this cycle's access.
// Assumes: op is already arbitrated (push wins over pop). In normal mode only the
// low field moves and the access address is confined to the internal RAM.
module stkp_arith
    import stkp_pkg::*;
#(
    parameter int PTR_W = 11,
    parameter int LO_W  = 8
) (
    input  logic [PTR_W-1:0] ptr,
    input  logic             ext,
    input  stk_op_e          op,
    output logic [PTR_W-1:0] ptr_nxt,
    output logic [PTR_W-1:0] acc_addr
);
    localparam int HI_W = PTR_W - LO_W;

    logic [PTR_W-1:0] inc_full, dec_full;
    logic [LO_W-1:0]  inc_lo, dec_lo;

    // Candidate results for both widths.
    always_comb begin
        inc_full = ptr + PTR_W'(1);
        dec_full = ptr - PTR_W'(1);
        inc_lo   = ptr[LO_W-1:0] + LO_W'(1);
        dec_lo   = ptr[LO_W-1:0] - LO_W'(1);
    end

    // Select the next pointer and the access address for the current operation.
    always_comb begin
        ptr_nxt  = ptr;
        acc_addr = ext ? ptr : {{HI_W{1'b0}}, ptr[LO_W-1:0]};
        case (op)
            OP_PUSH: begin
                ptr_nxt  = ext ? inc_full : {ptr[PTR_W-1:LO_W], inc_lo};
                acc_addr = ext ? inc_full : {{HI_W{1'b0}}, inc_lo};
            end
            OP_POP: begin
                ptr_nxt  = ext ? dec_full : {ptr[PTR_W-1:LO_W], dec_lo};
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/stkp_regif.sv
// Module: stkp_regif
// Register file view of the pointer: read mux, write decode, and the write-over-
// stack-operation merge that yields the pointer's next value.
// Assumes: the upper field is narrower than a register; unused bits read as 0.
module stkp_regif
    import stkp_pkg::*;
#(
    parameter int               PTR_W   = 11,
    parameter int               LO_W    = 8,
    parameter logic [7:0]       LO_ADDR = 8'h81,
    parameter logic [7:0]       HI_ADDR = 8'hB7
) (
    input  logic              reg_we,
    input  logic [7:0]        reg_addr,
    input  logic [REG_DW-1:0] reg_wdata,
    input  logic [PTR_W-1:0]  ptr_cur,
    input  logic [PTR_W-1:0]  ptr_op,
    output logic [PTR_W-1:0]  ptr_d,
    output logic [REG_DW-1:0] reg_rdata
);
    localparam int HI_W = PTR_W - LO_W;

    logic hit_lo, hit_hi;

    // Address decode.
    always_comb begin
        hit_lo = (reg_addr == LO_ADDR);
        hit_hi = (reg_addr == HI_ADDR);
    end

    // Read mux; upper bits of the high register are zero-filled.
    always_comb begin
        if (hit_lo)      reg_rdata = REG_DW'(ptr_cur[LO_W-1:0]);
        else if (hit_hi) reg_rdata = REG_DW'(ptr_cur[PTR_W-1:LO_W]);
        else             reg_rdata = '0;
    end

    // A register write replaces the stack operation's result.
    always_comb begin
        if (reg_we && hit_lo)
            ptr_d = {ptr_cur[PTR_W-1:LO_W], reg_wdata[LO_W-1:0]};
        else if (reg_we && hit_hi)
            ptr_d = {reg_wdata[HI_W-1:0], ptr_cur[LO_W-1:0]};
        else
            ptr_d = ptr_op;
    end
endmodule

// File: rtl/stk_ptr_unit.sv
// Module: stk_ptr_unit (top)
// Stack pointer with an optional 11-bit extended mode that reaches past the 256-byte
// internal RAM into extension RAM from 100h upward.
// Assumes: one stack operation per cycle at most is honoured (push wins); the
// memories act on stk_addr in the same cycle as the request.
module stk_ptr_unit
    import stkp_pkg::*;
#(
    parameter int         PTR_W   = 11,
    parameter int         LO_W    = 8,
    parameter logic [7:0] LO_ADDR = 8'h81,
    parameter logic [7:0] HI_ADDR = 8'hB7,
    parameter logic [7:0] RST_LO  = 8'h07
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_en,
    input  logic              pop_en,
    input  logic              cfg_we,
    input  logic              cfg_ext,
    input  logic              reg_we,
    input  logic [7:0]        reg_addr,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    output logic              ext_mode,
    output logic [PTR_W-1:0]  stk_addr,
    output logic              stk_in_xram
);
    localparam int HI_W = PTR_W - LO_W;

    logic [PTR_W-1:0] ptr_q, ptr_op, ptr_d;
    logic             ext_q;
    stk_op_e          op;

    // Arbitrate the stack request: push has priority.
    always_comb begin
        if (push_en)     op = OP_PUSH;
        else if (pop_en) op = OP_POP;
        else             op = OP_NONE;
    end

    stkp_arith #(.PTR_W(PTR_W), .LO_W(LO_W)) u_arith (
        .ptr      (ptr_q),
        .ext      (ext_q),
        .op       (op),
        .ptr_nxt  (ptr_op),
        .acc_addr (stk_addr)
    );

    stkp_regif #(.PTR_W(PTR_W), .LO_W(LO_W), .LO_ADDR(LO_ADDR), .HI_ADDR(HI_ADDR)) u_regif (
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .ptr_cur   (ptr_q),
        .ptr_op    (ptr_op),
        .ptr_d     (ptr_d),
        .reg_rdata (reg_rdata)
    );

    // Pointer register with reset value.
    always_ff @(posedge clk) begin
        if (!rst_n) ptr_q <= {{HI_W{1'b0}}, RST_LO[LO_W-1:0]};
        else        ptr_q <= ptr_d;
    end

    // Extension mode bit.
    always_ff @(posedge clk) begin
        if (!rst_n)      ext_q <= 1'b0;
        else if (cfg_we) ext_q <= cfg_ext;
    end

    // Memory select: anything above the internal 256 bytes is extension RAM.
    always_comb begin
        ext_mode    = ext_q;
        stk_in_xram = |stk_addr[PTR_W-1:LO_W];
    end
endmodule

// File: rtl/stkp_chk.sv
// Module: stkp_chk
// Concurrent checks on the stack pointer unit, bound into the top module.
module stkp_chk #(
    parameter int         PTR_W   = 11,
    parameter int         LO_W    = 8,
    parameter logic [7:0] HI_ADDR = 8'hB7,
    parameter logic [7:0] RST_LO  = 8'h07
) (
    input logic             clk,
    input logic             rst_n,
    input logic             push_en,
    input logic             pop_en,
    input logic             reg_we,
    input logic [7:0]       reg_addr,
    input logic [7:0]       reg_rdata,
    input logic [PTR_W-1:0] ptr_q,
    input logic             ext_q,
    input logic             stk_in_xram
);
    localparam int HI_W = PTR_W - LO_W;

    AST_RESET_VALUE: assert property (@(posedge clk) !rst_n |=> (ptr_q == PTR_W'(RST_LO)) && !ext_q); // R8
    AST_NORMAL_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (!ext_q && push_en && !reg_we && ptr_q[LO_W-1:0] == '1) |=> (ptr_q[LO_W-1:0] == '0)); // R1
    AST_EXT_CROSS: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_q && push_en && !reg_we && ptr_q == PTR_W'(255)) |=> (ptr_q == PTR_W'(256))); // R2
    AST_EXT_RETURN: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_q && pop_en && !push_en && !reg_we && ptr_q == PTR_W'(256)) |=> (ptr_q == PTR_W'(255))); // R3
    AST_NORMAL_INTERNAL: assert property (@(posedge clk) disable iff (!rst_n)
        !ext_q |-> !stk_in_xram); // R6
    AST_HI_PAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == HI_ADDR) |-> (reg_rdata[7:HI_W] == '0)); // R9
    AST_HI_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (!ext_q && (push_en || pop_en) && !reg_we) |=> $stable(ptr_q[PTR_W-1:LO_W])); // R12
endmodule

bind stk_ptr_unit stkp_chk #(.PTR_W(PTR_W), .LO_W(LO_W), .HI_ADDR(HI_ADDR), .RST_LO(RST_LO)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .push_en     (push_en),
    .pop_en      (pop_en),
    .reg_we      (reg_we),
    .reg_addr    (reg_addr),
    .reg_rdata   (reg_rdata),
    .ptr_q       (ptr_q),
    .ext_q       (ext_q),
    .stk_in_xram (stk_in_xram)
);

// File: tb/stk_ptr_unit_tb.sv
module stk_ptr_unit_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        push_en = 1'b0, pop_en = 1'b0, cfg_we = 1'b0, cfg_ext = 1'b0, reg_we = 1'b0;
    logic [7:0]  reg_addr = 8'h00, reg_wdata = 8'h00;
    logic [7:0]  reg_rdata;
    logic        ext_mode;
    logic [10:0] stk_addr;
    logic        stk_in_xram;

    int n_checks = 0;
    int n_errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    stk_ptr_unit u_dut (
        .clk(clk), .rst_n(rst_n), .push_en(push_en), .pop_en(pop_en),
        .cfg_we(cfg_we), .cfg_ext(cfg_ext), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ext_mode(ext_mode),
        .stk_addr(stk_addr), .stk_in_xram(stk_in_xram)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // One clocked cycle with the given request; returns the access seen in that cycle.
    task automatic cycle(input logic psh, input logic pp, input logic we, input logic [7:0] a,
                         input logic [7:0] d, output logic [10:0] addr_o, output logic flag_o);
        push_en = psh; pop_en = pp; reg_we = we; reg_addr = a; reg_wdata = d;
        #1;
        addr_o = stk_addr; flag_o = stk_in_xram;
        @(negedge clk);
        push_en = 1'b0; pop_en = 1'b0; reg_we = 1'b0;
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        logic [10:0] x; logic f;
        cycle(1'b0, 1'b0, 1'b1, a, d, x, f);
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        reg_addr = a; #1; d = reg_rdata;
    endtask

    task automatic set_ext(input logic b);
        cfg_we = 1'b1; cfg_ext = b;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic get_ptr(output int p);
        logic [7:0] lo, hi;
        rd(8'h81, lo); rd(8'hB7, hi);
        p = {hi[2:0], lo};
    endtask

    task automatic set_ptr(input int p);
        wr(8'hB7, 8'(p >> 8)); wr(8'h81, 8'(p));
    endtask

    task automatic t_reset();
        logic [7:0] d; logic [10:0] x; logic f;
        rd(8'h81, d); check("R8", "reset low byte", d, 8'h07);
        rd(8'hB7, d); check("R8", "reset high bits", d, 0);
        check("R8", "reset ext mode", ext_mode, 0);
        cycle(1'b0, 1'b1, 1'b0, 8'h00, 8'h00, x, f);
        check("R5", "pop address at reset pointer", x, 11'h007);
    endtask

    task automatic t_normal_wrap();
        logic [10:0] x; logic f; int p;
        set_ptr(11'h5FF);
        cycle(1'b1, 1'b0, 1'b0, 8'h00, 8'h00, x, f);
        check("R1", "normal push wrap address", x, 11'h000);
        check("R6", "normal push flag", f, 0);
        get_ptr(p);
        check("R12", "normal push keeps high bits", p, 11'h500);
        cycle(1'b0, 1'b1, 1'b0, 8'h00, 8'h00, x, f);
        check("R6", "normal pop address ignores high field", x, 11'h000);
        get_ptr(p);
        check("R12", "normal pop wraps low, keeps high", p, 11'h5FF);
        set_ptr(11'h030);
        cycle(1'b1, 1'b0, 1'b0, 8'h00, 8'h00, x, f);
        check("R5", "push pre-increment address", x, 11'h031);
    endtask

    task automatic t_ext_cross();
        logic [10:0] x; logic f; int p;
        set_ext(1'b1);
        check("R2", "ext mode on", ext_mode, 1);
        set_ptr(11'h0FF);
        cycle(1'b1, 1'b0, 1'b0, 8'h00, 8'h00, x, f);
        check("R2", "ext push address", x, 11'h100);
        check("R2", "ext push flag", f, 1);
        get_ptr(p);
        check("R2", "ext push pointer", p, 11'h100);
        cycle(1'b0, 1'b1, 1'b0, 8'h00, 8'h00, x, f);
        check("R3", "ext pop address", x, 11'h100);
        get_ptr(p);
        check("R3", "ext pop pointer", p, 11'h0FF);
        cycle(1'b0, 1'b1, 1'b0, 8'h00, 8'h00, x, f);
        check("R3", "second pop address", x, 11'h0FF);
        check("R6", "second pop flag internal", f, 0);
    endtask

    task automatic t_top();
        logic [10:0] x; logic f; int p;
        set_ptr(11'h7FF);
        cycle(1'b1, 1'b0, 1'b0, 8'h00, 8'h00, x, f);
        check("R4", "push past top address", x, 11'h000);
        get_ptr(p);
        check("R4", "push past top pointer", p, 11'h000);
        cycle(1'b0, 1'b1, 1'b0, 8'h00, 8'h00, x, f);
        check("R4", "pop from zero address", x, 11'h000);
        get_ptr(p);
        check("R4", "pop from zero pointer", p, 11'h7FF);
    endtask

    task automatic t_regs();
        logic [7:0] d;
        wr(8'hB7, 8'hFF);
        rd(8'hB7, d); check("R9", "high reg pad bits", d, 8'h07);
        wr(8'h81, 8'h5A);
        rd(8'h81, d); check("R7", "low byte readback", d, 8'h5A);
        rd(8'h80, d); check("R7", "unmapped address reads 0", d, 0);
    endtask

    task automatic t_collide();
        logic [10:0] x; logic f; int p;
        set_ptr(11'h123);
        cycle(1'b1, 1'b0, 1'b1, 8'h81, 8'h40, x, f);
        check("R10", "write+push access address", x, 11'h124);
        get_ptr(p);
        check("R10", "write+push pointer", p, 11'h140);
        set_ptr(11'h123);
        cycle(1'b1, 1'b1, 1'b0, 8'h00, 8'h00, x, f);
        check("R11", "push+pop address", x, 11'h124);
        get_ptr(p);
        check("R11", "push+pop pointer", p, 11'h124);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_errors++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_normal_wrap();
        t_ext_cross();
        t_top();
        t_regs();
        t_collide();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule